// File: doc/BRIEF.md
# Memory ECC Error Capture Unit

This block sits next to the ECC checker of a memory controller. The checker gives it one strobe per read access. That strobe carries a single-bit-error flag, a multi-bit-error flag, the 64-bit read data, the stored check field and the access address. The block filters single-bit errors through a programmable count threshold. It records the first reportable error in a set of capture registers and raises a level interrupt while an enabled error flag is set. Software reads the capture registers, then clears the flags by writing ones to them.

The same register space holds a data-corruption path for test. Two 32-bit masks and a control word can be XORed into the outgoing write data and check byte. This plants known errors in memory.

All registers are 32 bits wide and sit at word indexes 0 to 10 on a simple synchronous write / combinational read port. A configuration input selects between a 64-bit bus and a 32-bit bus. That choice decides how much of the check field is kept.

Top module: `mem_ecc_errcap`

## Requirements
- R1: The status register at index 0 holds the single-bit flag in bit 0, the multi-bit flag in bit 1 and the overrun bit in bit 3. Writing a one to any of these bits clears that bit and leaves the others unchanged. Writing 0xFFFFFFFF clears all three bits.
- R2: The detection-suppress register at index 1 resets to 0x3. Bit 0 blocks single-bit detection and bit 1 blocks multi-bit detection. Writing 0 enables both kinds of detection.
- R3: On the first reportable error, the block latches the following values. Index 4 holds data bits 63:32. Index 5 holds data bits 31:0. Index 7 holds the access address.
- R4: The interrupt-enable register at index 2 has the single-bit enable in bit 0 and the multi-bit enable in bit 1. The irq output is high exactly while some status flag in bits 1:0 is set together with its enable bit.
- R5: The threshold lives in bits 23:16 of index 3 and the running single-bit count in bits 7:0. Each detected single-bit error adds one to the count. When the incremented count reaches the threshold, the single-bit flag is set and the count returns to 0. A threshold of 0 or 1 (for example a write of 0x10000) reports every single-bit error.
- R6: The captured check field at index 6 keeps only bits 7:0 of the incoming 16-bit check field when narrow_bus is 0 (64-bit bus). It keeps all 16 bits when narrow_bus is 1 (32-bit bus).
- R7: While flag bit 0 or bit 1 is set, a further reportable error sets only bit 3. It does not change the capture registers or bits 1:0.
- R8: Index 8 holds the high data mask, index 9 the low data mask and index 10 the injection control word. All three can be written and read back in full, and all three reset to 0.
- R9: When bit 8 of the injection control word is 1, wr_data_out equals wr_data_in XOR {mask high, mask low} and wr_ecc_out equals wr_ecc_in XOR control bits 7:0. When bit 8 is 0, both outputs pass their inputs through unchanged.
- R10: Writes to indexes 4 to 7 have no effect. Indexes 11 to 15 read as 0.
- R11: A detected multi-bit error sets flag bit 1 at once, whatever the threshold and the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| narrow_bus | input | 1 | 1 selects a 32-bit memory bus, 0 selects a 64-bit bus |
| chk_valid | input | 1 | Checker result strobe for one access |
| chk_sbe | input | 1 | Single-bit error seen on this access |
| chk_mbe | input | 1 | Multi-bit error seen on this access |
| chk_data | input | 64 | Read data of the access |
| chk_ecc | input | 16 | Stored check field of the access |
| chk_addr | input | 32 | Address of the access |
| wr_data_in | input | 64 | Write data toward memory |
| wr_ecc_in | input | 8 | Check byte toward memory |
| wr_data_out | output | 64 | Write data after injection |
| wr_ecc_out | output | 8 | Check byte after injection |
| irq | output | 1 | Level interrupt |

## Verification
The bench goes after the capture lock. A second error that arrives while a flag is set must only raise the overrun bit. A design that overwrites the capture would hand software the data of the wrong access. The threshold sequence is stepped one error at a time and read back after each step. A counter that fails to reset, or that reports one error early or late, shows up as a wrong count field or a missing flag. Further checks cover the following: a partial clear must leave the other flags alone; masked enables must keep irq low with a flag set; the check field must be masked according to bus width; the injection XOR must act only when enabled. A long random phase with simultaneous writes and events is compared each cycle against a behavioural model.

// File: rtl/ecc_errcap_pkg.sv
// Shared register indexes and field positions of the ECC error capture unit.
package ecc_errcap_pkg;
    localparam int REG_AW = 4;
    localparam int REG_W  = 32;

    typedef enum logic [REG_AW-1:0] {
        RG_STAT     = 4'd0,
        RG_SUPPR    = 4'd1,
        RG_IEN      = 4'd2,
        RG_SBCTL    = 4'd3,
        RG_CAP_HI   = 4'd4,
        RG_CAP_LO   = 4'd5,
        RG_CAP_CHK  = 4'd6,
        RG_CAP_ADDR = 4'd7,
        RG_INJ_HI   = 4'd8,
        RG_INJ_LO   = 4'd9,
        RG_INJ_CTL  = 4'd10
    } reg_sel_e;

    localparam int ST_SBE      = 0;
    localparam int ST_MBE      = 1;
    localparam int ST_OVR      = 3;
    localparam logic [3:0] ST_MASK = 4'b1011;
    localparam int THR_LSB     = 16;
    localparam int INJ_EN_BIT  = 8;
endpackage

// File: rtl/ecc_err_track.sv
// Error tracking core: single-bit threshold counter, status flags, capture.
// Assumes at most one checker strobe per cycle; clear is applied before set.
module ecc_err_track
    import ecc_errcap_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 16,
    parameter int ECC_W  = 8,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_valid,
    input  logic              chk_sbe,
    input  logic              chk_mbe,
    input  logic [DATA_W-1:0] chk_data,
    input  logic [CHK_W-1:0]  chk_ecc,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic              narrow_bus,
    input  logic [1:0]        det_dis,
    input  logic              stat_wr,
    input  logic [3:0]        stat_clr,
    input  logic              sbctl_wr,
    input  logic [CNT_W-1:0]  thr_in,
    input  logic [CNT_W-1:0]  cnt_in,
    output logic [3:0]        stat_q,
    output logic [CNT_W-1:0]  thr_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [DATA_W-1:0] cap_data_q,
    output logic [CHK_W-1:0]  cap_chk_q,
    output logic [ADDR_W-1:0] cap_addr_q
);
    localparam int PAD_W = CHK_W - ECC_W;

    logic             sbe_ev, mbe_ev, sbe_hit, new_any, locked;
    logic [CNT_W:0]   cnt_inc;
    logic [3:0]       stat_nxt;
    logic [CHK_W-1:0] chk_kept;

    // Qualify strobes with the suppress bits and test the threshold.
    always_comb begin
        sbe_ev  = chk_valid && chk_sbe && !det_dis[0];
        mbe_ev  = chk_valid && chk_mbe && !det_dis[1];
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        sbe_hit = sbe_ev && (cnt_inc >= {1'b0, thr_q});
        new_any = sbe_hit || mbe_ev;
        locked  = stat_q[ST_SBE] || stat_q[ST_MBE];
    end

    // Next status: write-one-to-clear first, then new events.
    always_comb begin
        stat_nxt = stat_q & ~(stat_wr ? (stat_clr & ST_MASK) : 4'b0);
        if (new_any) begin
            if (locked) begin
                stat_nxt[ST_OVR] = 1'b1;
            end else begin
                stat_nxt[ST_SBE] = stat_nxt[ST_SBE] | sbe_hit;
                stat_nxt[ST_MBE] = stat_nxt[ST_MBE] | mbe_ev;
            end
        end
    end

    // Keep the check field width that matches the bus mode.
    always_comb begin
        chk_kept = narrow_bus ? chk_ecc : {{PAD_W{1'b0}}, chk_ecc[ECC_W-1:0]};
    end

    // Status flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_nxt;
    end

    // Threshold register, written only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)        thr_q <= '0;
        else if (sbctl_wr) thr_q <= thr_in;
    end

    // Single-bit error counter: software write wins, else count or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (sbctl_wr) cnt_q <= cnt_in;
        else if (sbe_hit)  cnt_q <= '0;
        else if (sbe_ev)   cnt_q <= cnt_inc[CNT_W-1:0];
    end

    // Capture of the first reportable error only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_data_q <= '0;
            cap_chk_q  <= '0;
            cap_addr_q <= '0;
        end else if (new_any && !locked) begin
            cap_data_q <= chk_data;
            cap_chk_q  <= chk_kept;
            cap_addr_q <= chk_addr;
        end
    end

    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !stat_wr) |=> ($stable(cap_data_q) && $stable(cap_addr_q) && $stable(cap_chk_q))); // R7
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && new_any) |=> stat_q[ST_OVR]); // R7
    AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sbe_hit && !sbctl_wr) |=> (cnt_q == '0)); // R5
    AST_MBE_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
        (det_dis[1] && !stat_q[ST_MBE]) |=> !stat_q[ST_MBE]); // R2
    AST_MBE_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_mbe && !det_dis[1] && !locked) |=> stat_q[ST_MBE]); // R11
endmodule

// File: rtl/ecc_inject.sv
// Error injection: holds two data masks and a control word, and corrupts the
// outgoing write data and check byte while the control enable bit is set.
module ecc_inject
    import ecc_errcap_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ECC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic              wr_ctl,
    input  logic [REG_W-1:0]  wdata,
    input  logic [DATA_W-1:0] wr_data_in,
    input  logic [ECC_W-1:0]  wr_ecc_in,
    output logic [REG_W-1:0]  mask_hi_q,
    output logic [REG_W-1:0]  mask_lo_q,
    output logic [REG_W-1:0]  ctl_q,
    output logic [DATA_W-1:0] wr_data_out,
    output logic [ECC_W-1:0]  wr_ecc_out
);
    logic inj_en;

    // Injection registers, plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_hi_q <= '0;
            mask_lo_q <= '0;
            ctl_q     <= '0;
        end else begin
            if (wr_hi)  mask_hi_q <= wdata;
            if (wr_lo)  mask_lo_q <= wdata;
            if (wr_ctl) ctl_q     <= wdata;
        end
    end

    // Apply the masks to the write path when enabled.
    always_comb begin
        inj_en      = ctl_q[INJ_EN_BIT];
        wr_data_out = wr_data_in ^ (inj_en ? {mask_hi_q, mask_lo_q} : '0);
        wr_ecc_out  = wr_ecc_in ^ (inj_en ? ctl_q[ECC_W-1:0] : '0);
    end

    AST_INJ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[INJ_EN_BIT] |-> (wr_data_out == wr_data_in && wr_ecc_out == wr_ecc_in)); // R9
endmodule

// File: rtl/mem_ecc_errcap.sv
// Top of the ECC error capture unit: register decode, suppress and enable
// registers, read mux and interrupt. Assumes reads are combinational.
module mem_ecc_errcap
    import ecc_errcap_pkg::*;
#(
    parameter int         DATA_W  = 64,
    parameter int         CHK_W   = 16,
    parameter int         ECC_W   = 8,
    parameter int         ADDR_W  = 32,
    parameter int         CNT_W   = 8,
    parameter logic [1:0] DIS_RST = 2'b11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              narrow_bus,
    input  logic              chk_valid,
    input  logic              chk_sbe,
    input  logic              chk_mbe,
    input  logic [DATA_W-1:0] chk_data,
    input  logic [CHK_W-1:0]  chk_ecc,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [DATA_W-1:0] wr_data_in,
    input  logic [ECC_W-1:0]  wr_ecc_in,
    output logic [DATA_W-1:0] wr_data_out,
    output logic [ECC_W-1:0]  wr_ecc_out,
    output logic              irq
);
    localparam int HALF_W = DATA_W / 2;

    logic [1:0]        dis_q, ien_q;
    logic [3:0]        stat_q;
    logic [CNT_W-1:0]  thr_q, cnt_q;
    logic [DATA_W-1:0] cap_data_q;
    logic [CHK_W-1:0]  cap_chk_q;
    logic [ADDR_W-1:0] cap_addr_q;
    logic [REG_W-1:0]  mask_hi_q, mask_lo_q, ctl_q;
    logic              wr_stat, wr_dis, wr_ien, wr_sb, wr_ihi, wr_ilo, wr_ictl;

    // Write strobe decode per register.
    always_comb begin
        wr_stat = reg_wr && (reg_addr == RG_STAT);
        wr_dis  = reg_wr && (reg_addr == RG_SUPPR);
        wr_ien  = reg_wr && (reg_addr == RG_IEN);
        wr_sb   = reg_wr && (reg_addr == RG_SBCTL);
        wr_ihi  = reg_wr && (reg_addr == RG_INJ_HI);
        wr_ilo  = reg_wr && (reg_addr == RG_INJ_LO);
        wr_ictl = reg_wr && (reg_addr == RG_INJ_CTL);
    end

    // Detection suppress and interrupt enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q <= DIS_RST;
            ien_q <= '0;
        end else begin
            if (wr_dis) dis_q <= reg_wdata[1:0];
            if (wr_ien) ien_q <= reg_wdata[1:0];
        end
    end

    ecc_err_track #(
        .DATA_W(DATA_W), .CHK_W(CHK_W), .ECC_W(ECC_W),
        .ADDR_W(ADDR_W), .CNT_W(CNT_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .chk_valid  (chk_valid),
        .chk_sbe    (chk_sbe),
        .chk_mbe    (chk_mbe),
        .chk_data   (chk_data),
        .chk_ecc    (chk_ecc),
        .chk_addr   (chk_addr),
        .narrow_bus (narrow_bus),
        .det_dis    (dis_q),
        .stat_wr    (wr_stat),
        .stat_clr   (reg_wdata[3:0]),
        .sbctl_wr   (wr_sb),
        .thr_in     (reg_wdata[THR_LSB +: CNT_W]),
        .cnt_in     (reg_wdata[CNT_W-1:0]),
        .stat_q     (stat_q),
        .thr_q      (thr_q),
        .cnt_q      (cnt_q),
        .cap_data_q (cap_data_q),
        .cap_chk_q  (cap_chk_q),
        .cap_addr_q (cap_addr_q)
    );

    ecc_inject #(.DATA_W(DATA_W), .ECC_W(ECC_W)) u_inject (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_hi       (wr_ihi),
        .wr_lo       (wr_ilo),
        .wr_ctl      (wr_ictl),
        .wdata       (reg_wdata),
        .wr_data_in  (wr_data_in),
        .wr_ecc_in   (wr_ecc_in),
        .mask_hi_q   (mask_hi_q),
        .mask_lo_q   (mask_lo_q),
        .ctl_q       (ctl_q),
        .wr_data_out (wr_data_out),
        .wr_ecc_out  (wr_ecc_out)
    );

    // Read mux; unmapped indexes return zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RG_STAT:     reg_rdata[3:0] = stat_q;
            RG_SUPPR:    reg_rdata[1:0] = dis_q;
            RG_IEN:      reg_rdata[1:0] = ien_q;
            RG_SBCTL:    reg_rdata = {{(REG_W-THR_LSB-CNT_W){1'b0}}, thr_q,
                                      {(THR_LSB-CNT_W){1'b0}}, cnt_q};
            RG_CAP_HI:   reg_rdata = cap_data_q[DATA_W-1:HALF_W];
            RG_CAP_LO:   reg_rdata = cap_data_q[HALF_W-1:0];
            RG_CAP_CHK:  reg_rdata[CHK_W-1:0] = cap_chk_q;
            RG_CAP_ADDR: reg_rdata = cap_addr_q;
            RG_INJ_HI:   reg_rdata = mask_hi_q;
            RG_INJ_LO:   reg_rdata = mask_lo_q;
            RG_INJ_CTL:  reg_rdata = ctl_q;
            default:     reg_rdata = '0;
        endcase
    end

    // Level interrupt from enabled flags.
    always_comb begin
        irq = |(stat_q[1:0] & ien_q);
    end

    AST_CLEAR_ALL_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && (&reg_wdata) && !chk_valid) |=> !irq); // R1
endmodule

// File: tb/sim_mem_ecc_errcap.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks against literal values.
module sim_mem_ecc_errcap;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        narrow_bus, chk_valid, chk_sbe, chk_mbe;
    logic [63:0] chk_data;
    logic [15:0] chk_ecc;
    logic [31:0] chk_addr;
    logic [63:0] wr_data_in, wr_data_out;
    logic [7:0]  wr_ecc_in, wr_ecc_out;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    logic [3:0]  m_stat;
    logic [1:0]  m_dis, m_ien;
    int          m_thr, m_cnt;
    logic [63:0] m_cdata;
    logic [15:0] m_cchk;
    logic [31:0] m_caddr, m_ihi, m_ilo, m_ictl;

    mem_ecc_errcap u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .narrow_bus(narrow_bus),
        .chk_valid(chk_valid), .chk_sbe(chk_sbe), .chk_mbe(chk_mbe),
        .chk_data(chk_data), .chk_ecc(chk_ecc), .chk_addr(chk_addr),
        .wr_data_in(wr_data_in), .wr_ecc_in(wr_ecc_in),
        .wr_data_out(wr_data_out), .wr_ecc_out(wr_ecc_out), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string req_of(input logic [3:0] a);
        case (a)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R4";
            4'd3: return "R5";
            4'd4, 4'd5, 4'd7: return "R3";
            4'd6: return "R6";
            4'd8, 4'd9, 4'd10: return "R8";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [31:0] model_rd(input logic [3:0] a);
        case (a)
            4'd0: return {28'd0, m_stat};
            4'd1: return {30'd0, m_dis};
            4'd2: return {30'd0, m_ien};
            4'd3: return (32'(m_thr) << 16) | 32'(m_cnt);
            4'd4: return m_cdata[63:32];
            4'd5: return m_cdata[31:0];
            4'd6: return {16'd0, m_cchk};
            4'd7: return m_caddr;
            4'd8: return m_ihi;
            4'd9: return m_ilo;
            4'd10: return m_ictl;
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_update();
        bit sev, mev, hit, busy;
        int ncnt;
        logic [3:0] ns;
        if (!rst_n) begin
            m_stat = 0; m_dis = 2'b11; m_ien = 0; m_thr = 0; m_cnt = 0;
            m_cdata = 0; m_cchk = 0; m_caddr = 0; m_ihi = 0; m_ilo = 0; m_ictl = 0;
            return;
        end
        sev = chk_valid && chk_sbe && !m_dis[0];
        mev = chk_valid && chk_mbe && !m_dis[1];
        hit = 0; ncnt = m_cnt;
        if (sev) begin
            if (m_cnt + 1 >= m_thr) begin hit = 1; ncnt = 0; end
            else ncnt = m_cnt + 1;
        end
        busy = m_stat[0] || m_stat[1];
        ns = m_stat;
        if (reg_wr && reg_addr == 4'd0) ns = ns & ~(reg_wdata[3:0] & 4'b1011);
        if (hit || mev) begin
            if (busy) ns[3] = 1'b1;
            else begin
                if (hit) ns[0] = 1'b1;
                if (mev) ns[1] = 1'b1;
                m_cdata = chk_data;
                m_cchk  = narrow_bus ? chk_ecc : {8'd0, chk_ecc[7:0]};
                m_caddr = chk_addr;
            end
        end
        m_stat = ns;
        m_cnt = ncnt;
        if (reg_wr) begin
            case (reg_addr)
                4'd1: m_dis = reg_wdata[1:0];
                4'd2: m_ien = reg_wdata[1:0];
                4'd3: begin m_thr = int'(reg_wdata[23:16]); m_cnt = int'(reg_wdata[7:0]); end
                4'd8: m_ihi = reg_wdata;
                4'd9: m_ilo = reg_wdata;
                4'd10: m_ictl = reg_wdata;
                default: ;
            endcase
        end
    endtask

    task automatic compare();
        logic [63:0] ed;
        logic [7:0]  ee;
        ed = m_ictl[8] ? (wr_data_in ^ {m_ihi, m_ilo}) : wr_data_in;
        ee = m_ictl[8] ? (wr_ecc_in ^ m_ictl[7:0]) : wr_ecc_in;
        chk("R4 irq", 64'(irq), 64'(|(m_stat[1:0] & m_ien)));
        chk(req_of(reg_addr), 64'(reg_rdata), 64'(model_rd(reg_addr)));
        chk("R9 data", wr_data_out, ed);
        chk("R9 ecc", 64'(wr_ecc_out), 64'(ee));
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 0;
    endtask

    task automatic ev(input bit s, input bit m, input logic [63:0] d,
                      input logic [15:0] e, input logic [31:0] a);
        chk_valid = 1; chk_sbe = s; chk_mbe = m; chk_data = d; chk_ecc = e; chk_addr = a;
        tick();
        chk_valid = 0; chk_sbe = 0; chk_mbe = 0;
    endtask

    task automatic expect_reg(input string req, input logic [3:0] a, input logic [31:0] v);
        reg_addr = a;
        tick();
        chk(req, 64'(reg_rdata), 64'(v));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; narrow_bus = 0;
        chk_valid = 0; chk_sbe = 0; chk_mbe = 0; chk_data = 0; chk_ecc = 0; chk_addr = 0;
        wr_data_in = 64'h1122334455667788; wr_ecc_in = 8'h3C;
        tick(); tick();
        expect_reg("R2 reset", 4'd1, 32'h3);
        rst_n = 1;
        expect_reg("R1 reset", 4'd0, 32'h0);
        // R2: suppressed by default
        ev(1, 1, 64'hDEAD, 16'h1, 32'h10);
        expect_reg("R2 suppressed", 4'd0, 32'h0);
        wr(4'd1, 32'h0);
        wr(4'd2, 32'h3);
        wr(4'd3, 32'h0001_0000);
        // R3/R5/R6: first single-bit error
        ev(1, 0, 64'h0123456789ABCDEF, 16'hC35A, 32'h1000_0040);
        expect_reg("R5 every error", 4'd0, 32'h1);
        chk("R4 irq set", 64'(irq), 64'd1);
        expect_reg("R3 hi", 4'd4, 32'h01234567);
        expect_reg("R3 lo", 4'd5, 32'h89ABCDEF);
        expect_reg("R3 addr", 4'd7, 32'h1000_0040);
        expect_reg("R6 wide mask", 4'd6, 32'h5A);
        // R7: second error while locked
        ev(0, 1, 64'hFFFF_0000_FFFF_0000, 16'h77, 32'h2000);
        expect_reg("R7 overrun", 4'd0, 32'h9);
        expect_reg("R7 hold lo", 4'd5, 32'h89ABCDEF);
        // R1: partial clear then full clear
        wr(4'd0, 32'h1);
        expect_reg("R1 partial", 4'd0, 32'h8);
        chk("R4 irq low", 64'(irq), 64'd0);
        wr(4'd0, 32'hFFFF_FFFF);
        expect_reg("R1 all", 4'd0, 32'h0);
        // R11/R6: narrow bus multi-bit
        narrow_bus = 1;
        ev(0, 1, 64'h5, 16'hC35A, 32'h3000);
        expect_reg("R11 mbe", 4'd0, 32'h2);
        expect_reg("R6 narrow", 4'd6, 32'hC35A);
        narrow_bus = 0;
        wr(4'd0, 32'hFFFF_FFFF);
        // R5: threshold 3
        wr(4'd3, 32'h0003_0000);
        ev(1, 0, 64'h1, 16'h0, 32'h40);
        expect_reg("R5 count1", 4'd3, 32'h0003_0001);
        expect_reg("R5 noflag", 4'd0, 32'h0);
        ev(1, 0, 64'h2, 16'h0, 32'h44);
        expect_reg("R5 count2", 4'd3, 32'h0003_0002);
        ev(1, 0, 64'h3, 16'h0, 32'h48);
        expect_reg("R5 flag", 4'd0, 32'h1);
        expect_reg("R5 wrap", 4'd3, 32'h0003_0000);
        expect_reg("R3 third addr", 4'd7, 32'h48);
        // R4: enable masking
        wr(4'd0, 32'hF);
        wr(4'd2, 32'h1);
        ev(0, 1, 64'h9, 16'h0, 32'h50);
        expect_reg("R4 flag set", 4'd0, 32'h2);
        chk("R4 masked irq", 64'(irq), 64'd0);
        // R10: read-only capture, unmapped reads
        wr(4'd5, 32'hFFFF);
        expect_reg("R10 ro", 4'd5, 32'h9);
        wr(4'd12, 32'hFFFF_FFFF);
        expect_reg("R10 unmapped", 4'd12, 32'h0);
        // R8/R9: injection
        wr(4'd8, 32'hF000_0000);
        wr(4'd9, 32'h1);
        wr(4'd10, 32'hA5);
        expect_reg("R8 ctl", 4'd10, 32'hA5);
        chk("R9 off", wr_data_out, 64'h1122334455667788);
        wr(4'd10, 32'h1A5);
        chk("R9 on data", wr_data_out, 64'hE122334455667789);
        chk("R9 on ecc", 64'(wr_ecc_out), 64'h99);
        expect_reg("R8 hi", 4'd8, 32'hF000_0000);
        // random phase against the model
        for (int i = 0; i < 2000; i++) begin
            chk_valid  = ($urandom % 3) == 0;
            chk_sbe    = $urandom % 2;
            chk_mbe    = ($urandom % 4) == 0;
            chk_data   = {$urandom, $urandom};
            chk_ecc    = 16'($urandom);
            chk_addr   = $urandom;
            narrow_bus = $urandom % 2;
            reg_wr     = ($urandom % 6) == 0;
            reg_addr   = 4'($urandom);
            reg_wdata  = (reg_addr == 4'd3) ? ($urandom & 32'h0007_0003) : $urandom;
            wr_data_in = {$urandom, $urandom};
            wr_ecc_in  = 8'($urandom);
            tick();
        end
        reg_wr = 0; chk_valid = 0;
        finish_run();
    end
endmodule